// File: doc/BRIEF.md
# Two-Digit BCD Adder/Subtractor

This unit adds or subtracts two unsigned decimal numbers, each held as a packed BCD byte with the tens digit in bits [7:4] and the units digit in bits [3:0]. It does not use dedicated decimal adders. It first forms a plain binary sum and keeps the carry out of every nibble. A per-digit correction stage then turns that sum into a decimal result. In add mode the correction adds 6 to a digit. In subtract mode it takes 6 away.

Subtraction uses the same binary adder. The subtrahend is inverted and a carry-in of one is applied. A missing nibble carry then means a borrow out of that digit. The unit returns one BCD result byte and a single flag: the decimal carry when adding, the borrow when subtracting. Both are registered and appear one clock after the request. Operands are assumed to be valid BCD.

Top module: `bcd_addsub`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `result` and `flag` read zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: With `op_sub` = 0 (add), `result` holds (A + B) mod 100 in packed BCD, where A and B are the decimal values of `a` and `b`.
- R4: With `op_sub` = 0, `flag` is 1 exactly when A + B is 100 or more.
- R5: In add mode, when the two units digits sum to 10 through 18, the units digit of the result is that sum minus 10, and one is carried into the tens digit.
- R6: In add mode, when the units correction carries into a tens digit that would then reach ten (for example 95 + 05), the tens digit becomes 0 and `flag` is set.
- R7: With `op_sub` = 1 (subtract), `result` holds (A − B + 100) mod 100 in packed BCD. This is the hundred's complement of the difference when A < B.
- R8: With `op_sub` = 1, `flag` is 1 exactly when A < B.
- R9: Subtracting equal operands gives `result` = 8'h00 and `flag` = 0.
- R10: In a cycle after `in_valid` was low, `result` and `flag` keep the values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_sub | input | 1 | 0 = add, 1 = subtract (a − b) |
| a | input | 8 | First operand, packed BCD (tens in [7:4]) |
| b | input | 8 | Second operand, packed BCD (tens in [7:4]) |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result | output | 8 | Packed BCD sum or difference |
| flag | output | 1 | Decimal carry (add) or borrow (subtract) |

## Verification
The hardest case to reach is the correction chain in add mode. It occurs when adding 6 to the units digit overflows into a tens nibble that was already 9, or sometimes already 15, so the tens digit needs its own correction even though the binary tens sum carried nothing. Subtract mode has a matching hard case: a borrow from both digits at once, which leaves a hundred's-complement byte. The stimulus sweeps all ten thousand valid operand pairs in each mode. This covers every such combination, including 95 + 05, 96 + 65 and 00 − 99. Idle cycles are inserted at irregular points so that the hold behaviour is observed between real results.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [4:0] DEC_LIMIT = 5'd9;
    localparam logic [4:0] ADJUST = 5'd6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // outcome of correcting one decimal digit
    typedef struct packed {
        logic [DIGIT_W-1:0] nib;      // corrected digit
        logic               ripple;   // overflow of the +6 into the next nibble
        logic               dec_out;  // decimal carry (add) or borrow (sub)
    } digit_fix_t;

    function automatic logic above_nine(input logic [4:0] v);
        return v > DEC_LIMIT;
    endfunction

endpackage

// File: rtl/bcd_bin_add.sv
module bcd_bin_add
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = DIGITS * DIGIT_W
) (
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    input  op_e               op,
    output logic [W-1:0]      sum,
    output logic [DIGITS-1:0] nib_carry
);

    logic [W-1:0]  y_eff;
    logic [DIGITS:0] chain;

    assign y_eff    = (op == OP_SUB) ? ~y : y;
    assign chain[0] = (op == OP_SUB);

    for (genvar d = 0; d < DIGITS; d++) begin : g_nib
        logic [DIGIT_W:0] part;
        always_comb begin
            part = {1'b0, x[d*DIGIT_W +: DIGIT_W]}
                 + {1'b0, y_eff[d*DIGIT_W +: DIGIT_W]}
                 + {{DIGIT_W{1'b0}}, chain[d]};
        end
        assign sum[d*DIGIT_W +: DIGIT_W] = part[DIGIT_W-1:0];
        assign chain[d+1]                = part[DIGIT_W];
        assign nib_carry[d]              = part[DIGIT_W];
    end

endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
    import bcd_addsub_pkg::*;
(
    input  logic [DIGIT_W-1:0] nib_in,
    input  logic               nib_carry,
    input  logic               ripple_in,
    input  op_e                op,
    output digit_fix_t         fix
);

    logic [4:0] t;
    logic [4:0] plus6;
    logic [4:0] minus6;
    logic       need;

    always_comb begin
        t      = {1'b0, nib_in} + {4'b0, ripple_in & (op == OP_ADD)};
        plus6  = t + ADJUST;
        minus6 = {1'b0, nib_in} - ADJUST;
        fix    = '0;
        if (op == OP_ADD) begin
            need        = nib_carry | above_nine(t);
            fix.nib     = need ? plus6[DIGIT_W-1:0] : t[DIGIT_W-1:0];
            fix.ripple  = need & plus6[4];
            fix.dec_out = need;
        end else begin
            // no carry out of the nibble means it borrowed
            need        = ~nib_carry | above_nine({1'b0, nib_in});
            fix.nib     = need ? minus6[DIGIT_W-1:0] : nib_in;
            fix.ripple  = 1'b0;
            fix.dec_out = ~nib_carry;
        end
    end

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
    import bcd_addsub_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = DIGITS * DIGIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         op_sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         flag
);

    op_e               op;
    logic [W-1:0]      bin_sum;
    logic [DIGITS-1:0] nib_carry;
    digit_fix_t        fix [DIGITS];
    logic [DIGITS:0]   ripple;
    logic [W-1:0]      dec_sum;

    assign op        = op_sub ? OP_SUB : OP_ADD;
    assign ripple[0] = 1'b0;

    bcd_bin_add #(.DIGITS(DIGITS)) u_bin (
        .x        (a),
        .y        (b),
        .op       (op),
        .sum      (bin_sum),
        .nib_carry(nib_carry)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_fix
        bcd_digit_fix u_fix (
            .nib_in   (bin_sum[d*DIGIT_W +: DIGIT_W]),
            .nib_carry(nib_carry[d]),
            .ripple_in(ripple[d]),
            .op       (op),
            .fix      (fix[d])
        );
        assign ripple[d+1]                   = fix[d].ripple;
        assign dec_sum[d*DIGIT_W +: DIGIT_W] = fix[d].nib;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= dec_sum;
                flag   <= fix[DIGITS-1].dec_out;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flag))); // R10
    AST_EQ_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sub && a == b) |=> (result == '0 && !flag)); // R9
    AST_ADD_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sub && a == '0) |=> (result == $past(b) && !flag)); // R3

endmodule

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       out_valid;
    logic [7:0] result;
    logic       flag;

    int checks = 0;
    int errors = 0;
    int exp_res_q[$];
    int exp_flag_q[$];
    int tag_q[$];
    int last_res = 0;
    int last_flag = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bcd_addsub u_bcd_addsub (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_sub   (op_sub),
        .a        (a),
        .b        (b),
        .out_valid(out_valid),
        .result   (result),
        .flag     (flag)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic string res_tag(input int c);
        case (c)
            5: return "R5";
            6: return "R6";
            7: return "R7";
            9: return "R9";
            default: return "R3";
        endcase
    endfunction

    function automatic string flag_tag(input int c);
        case (c)
            3: return "R4";
            7: return "R8";
            default: return res_tag(c);
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit v, input bit s, input int x, input int y);
        int r, f, t, sx, sy;
        @(negedge clk);
        if (exp_res_q.size() > 0) begin
            r = exp_res_q.pop_front();
            f = exp_flag_q.pop_front();
            t = tag_q.pop_front();
            check("R2", int'(out_valid), 1);
            check(res_tag(t), int'(result), r);
            check(flag_tag(t), int'(flag), f);
            last_res  = r;
            last_flag = f;
        end else begin
            check("R2", int'(out_valid), 0);
            check("R10", int'(result), last_res);
            check("R10", int'(flag), last_flag);
        end
        in_valid = v;
        op_sub   = s;
        a        = to_bcd(x);
        b        = to_bcd(y);
        if (v) begin
            if (!s) begin
                sx = x % 10 + y % 10;
                sy = x / 10 + y / 10;
                exp_res_q.push_back(int'(to_bcd((x + y) % 100)));
                exp_flag_q.push_back((x + y) >= 100 ? 1 : 0);
                if (sx >= 10 && sy == 9) tag_q.push_back(6);
                else if (sx >= 10) tag_q.push_back(5);
                else tag_q.push_back(3);
            end else begin
                exp_res_q.push_back(int'(to_bcd((x - y + 100) % 100)));
                exp_flag_q.push_back(x < y ? 1 : 0);
                tag_q.push_back(x == y ? 9 : 7);
            end
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", int'(out_valid), 0);
        check("R1", int'(result), 0);
        check("R1", int'(flag), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset
        check("R1", int'(out_valid), 0);
        check("R1", int'(result), 0);
        check("R1", int'(flag), 0);
        for (int m = 0; m < 2; m++) begin
            for (int x = 0; x < 100; x++) begin
                for (int y = 0; y < 100; y++) begin
                    cycle(1'b1, m[0], x, y);
                    if (((x * 100 + y) % 37) == 11) cycle(1'b0, 1'b0, 0, 0);
                end
            end
        end
        repeat (3) cycle(1'b0, 1'b0, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule